// File: doc/BRIEF.md
# Priority Interrupt Acceptance Controller

This block sits between a set of level-sensitive interrupt request lines and a simple synchronous register bus. Each source has its own 4-bit priority. Priority 0 switches the source off. The controller keeps a current interrupt level and a one-deep saved copy of the previous level. It raises a single request line to the processor whenever some source is pending at a priority strictly above the current level.

Acceptance is a side effect of one read. Reading the accept register picks the winning source and returns its vector. In the same clock edge it copies the current level into the saved-level register, raises the current level to the winner's priority and latches the vector in the event register. A handler reads the saved level and writes it back into the current-level register to restore the masking that was in force before. The vector of source `n` is `(n + 16) << 5`. A vector of zero means nothing was accepted.

Read data comes back one cycle after the read is enabled. A small response state machine drives the read data. It has three states. `RSP_IDLE` is entered after any cycle without a read, and read data is then zero. `RSP_ACCEPT` is entered after an accept-register read. `RSP_REG` is entered after any other read. If a write and a read are enabled in the same cycle, the write is dropped.

Top module: `intc_accept_top`

## Requirements
- R1: After reset, every source priority, the current level, the saved level and the event register are zero, and both `irq_o` and `bus_rdata_o` are low.
- R2: `irq_o` is high exactly when some source has its request line high and a priority strictly greater than the current level. A source at priority 0 never raises it.
- R3: A read of byte address 0x18 returns, in the following cycle, the vector `(n + 16) << 5` of the eligible source `n` with the highest priority.
- R4: When several eligible sources share the highest priority, the one with the lowest index is accepted.
- R5: On an accept read that finds a winner, the saved level (read at 0x34, bits [3:0]) takes the old current level, and the current level (read at 0x30, bits [3:0]) takes the winner's priority, both at the same edge.
- R6: An accept read with no eligible source returns zero and leaves both the current and the saved level unchanged.
- R7: The event register at 0x20 returns the vector latched by the most recent accept read, or zero if that read found no source.
- R8: A write to 0x30 with byte enable 0 set loads wdata[3:0] into the current level. A write to 0x30 without byte enable 0 is ignored. The saved level at 0x34 cannot be written and changes only on an accept read that finds a winner.
- R9: Source priorities live at 0x40 (sources 0 to 7) and 0x44 (sources 8 to 15). Source `n` occupies bits `4*(n%8)+3 : 4*(n%8)` and is written only when the byte enable of its byte lane is set. These words read back as written.
- R10: Reads of addresses other than 0x18 change no state. `bus_rdata_o` is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 16 | Level-sensitive request line of each source |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_we_i | input | 1 | Write enable |
| bus_be_i | input | 4 | Byte lane enables for a write |
| bus_wdata_i | input | 32 | Write data |
| bus_re_i | input | 1 | Read enable; side effects happen in this cycle |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the read |
| irq_o | output | 1 | Request to the processor |

## Verification
The hardest situation to reach from the ports is a nested acceptance. A second, higher-priority source must win while the level raised by the first acceptance is still in force, and the saved level must then hold the first winner's priority instead of the reset value. The stimulus reaches this in steps. It first writes a non-zero current level, accepts a middle-priority source, and only then raises a higher one. It follows with a restore write from the saved copy. Tie-breaking and the empty accept, whose path leaves the levels untouched, are reached on purpose: two sources get equal priorities, and the level is raised until every pending source sits at or below it.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    localparam int unsigned NSRC_DEF = 16;
    localparam int unsigned PW_DEF   = 4;
    localparam int unsigned AW_DEF   = 8;
    localparam int unsigned DW_DEF   = 32;

    // Byte offsets of the register map
    localparam logic [7:0] OFF_ACCEPT = 8'h18;
    localparam logic [7:0] OFF_EVENT  = 8'h20;
    localparam logic [7:0] OFF_CUR    = 8'h30;
    localparam logic [7:0] OFF_PREV   = 8'h34;
    localparam logic [7:0] OFF_PRIO   = 8'h40;

    localparam int unsigned VEC_BASE  = 16;
    localparam int unsigned VEC_SHIFT = 5;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_ACCEPT,
        RSP_REG
    } rsp_state_e;

    function automatic logic [31:0] vec_of(input logic [31:0] idx);
        vec_of = (idx + VEC_BASE) << VEC_SHIFT;
    endfunction
endpackage

// File: rtl/intc_prio_bank.sv
`timescale 1ns/1ps
module intc_prio_bank
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = NSRC_DEF,
    parameter int unsigned PW   = PW_DEF,
    parameter int unsigned AW   = AW_DEF,
    parameter int unsigned DW   = DW_DEF
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     we_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [DW/8-1:0]          be_i,
    input  logic [DW-1:0]            wdata_i,
    output logic [NSRC-1:0][PW-1:0]  prio_o,
    output logic [DW-1:0]            rdata_o,
    output logic                     hit_o
);
    localparam int unsigned PER_WORD = DW / PW;
    localparam int unsigned NWORD    = (NSRC + PER_WORD - 1) / PER_WORD;
    localparam int unsigned WAW      = AW - 2;
    localparam logic [WAW-1:0] BASE_W = WAW'(OFF_PRIO >> 2);

    logic [WAW-1:0] word_sel;

    assign word_sel = addr_i[AW-1:2] - BASE_W;
    assign hit_o    = (addr_i[AW-1:2] >= BASE_W) &&
                      (word_sel < WAW'(NWORD)) &&
                      (addr_i[1:0] == 2'b00);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int unsigned SLOT = i % PER_WORD;
        localparam int unsigned WIDX = i / PER_WORD;
        localparam int unsigned LANE = (SLOT * PW) / 8;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                prio_o[i] <= '0;
            end else if (we_i && hit_o && (word_sel == WAW'(WIDX)) && be_i[LANE]) begin
                prio_o[i] <= wdata_i[SLOT*PW +: PW];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (word_sel == WAW'(i / PER_WORD)) begin
                rdata_o[(i % PER_WORD)*PW +: PW] = prio_o[i];
            end
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = NSRC_DEF,
    parameter int unsigned PW   = PW_DEF,
    localparam int unsigned IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]          req_i,
    input  logic [NSRC-1:0][PW-1:0]  prio_i,
    input  logic [PW-1:0]            level_i,
    output logic                     found_o,
    output logic [IW-1:0]            win_idx_o,
    output logic [PW-1:0]            win_prio_o
);
    // Ascending scan with strict comparison: an equal priority later in
    // the scan cannot displace an earlier (lower-index) winner.
    always_comb begin
        found_o    = 1'b0;
        win_idx_o  = '0;
        win_prio_o = level_i;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && (prio_i[i] > win_prio_o)) begin
                found_o    = 1'b1;
                win_idx_o  = IW'(i);
                win_prio_o = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/intc_level_ctrl.sv
`timescale 1ns/1ps
module intc_level_ctrl
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = NSRC_DEF,
    parameter int unsigned PW   = PW_DEF,
    parameter int unsigned DW   = DW_DEF,
    localparam int unsigned IW  = $clog2(NSRC)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           accept_i,
    input  logic           found_i,
    input  logic [IW-1:0]  win_idx_i,
    input  logic [PW-1:0]  win_prio_i,
    input  logic           lvl_we_i,
    input  logic [PW-1:0]  lvl_wdata_i,
    output logic [PW-1:0]  cur_o,
    output logic [PW-1:0]  prev_o,
    output logic [DW-1:0]  evt_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_o  <= '0;
            prev_o <= '0;
            evt_o  <= '0;
        end else if (accept_i) begin
            if (found_i) begin
                prev_o <= cur_o;
                cur_o  <= win_prio_i;
                evt_o  <= DW'(vec_of(32'(win_idx_i)));
            end else begin
                evt_o  <= '0;
            end
        end else if (lvl_we_i) begin
            cur_o <= lvl_wdata_i;
        end
    end
endmodule

// File: rtl/intc_accept_top.sv
`timescale 1ns/1ps
module intc_accept_top
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = NSRC_DEF,
    parameter int unsigned PW   = PW_DEF,
    parameter int unsigned AW   = AW_DEF,
    parameter int unsigned DW   = DW_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   irq_req_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DW/8-1:0]   bus_be_i,
    input  logic [DW-1:0]     bus_wdata_i,
    input  logic              bus_re_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              irq_o
);
    localparam int unsigned IW = $clog2(NSRC);

    logic [NSRC-1:0][PW-1:0] prio;
    logic [DW-1:0]           prio_rdata;
    logic                    prio_hit;
    logic                    found;
    logic [IW-1:0]           win_idx;
    logic [PW-1:0]           win_prio;
    logic [PW-1:0]           cur_lvl;
    logic [PW-1:0]           prev_lvl;
    logic [DW-1:0]           evt_vec;
    logic                    wr_ok;
    logic                    is_accept;
    logic                    lvl_we;

    rsp_state_e              state_q, state_d;
    logic [DW-1:0]           data_q, data_d;

    assign wr_ok     = bus_we_i && !bus_re_i;
    assign is_accept = bus_re_i && (bus_addr_i == AW'(OFF_ACCEPT));
    assign lvl_we    = wr_ok && (bus_addr_i == AW'(OFF_CUR)) && bus_be_i[0];

    intc_prio_bank #(.NSRC(NSRC), .PW(PW), .AW(AW), .DW(DW)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_ok),
        .addr_i  (bus_addr_i),
        .be_i    (bus_be_i),
        .wdata_i (bus_wdata_i),
        .prio_o  (prio),
        .rdata_o (prio_rdata),
        .hit_o   (prio_hit)
    );

    intc_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
        .req_i      (irq_req_i),
        .prio_i     (prio),
        .level_i    (cur_lvl),
        .found_o    (found),
        .win_idx_o  (win_idx),
        .win_prio_o (win_prio)
    );

    intc_level_ctrl #(.NSRC(NSRC), .PW(PW), .DW(DW)) u_lvl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .accept_i    (is_accept),
        .found_i     (found),
        .win_idx_i   (win_idx),
        .win_prio_i  (win_prio),
        .lvl_we_i    (lvl_we),
        .lvl_wdata_i (bus_wdata_i[PW-1:0]),
        .cur_o       (cur_lvl),
        .prev_o      (prev_lvl),
        .evt_o       (evt_vec)
    );

    assign irq_o = found;

    // Next state and captured read data
    always_comb begin
        state_d = RSP_IDLE;
        data_d  = '0;
        if (is_accept) begin
            state_d = RSP_ACCEPT;
            data_d  = found ? DW'(vec_of(32'(win_idx))) : '0;
        end else if (bus_re_i) begin
            state_d = RSP_REG;
            if (bus_addr_i == AW'(OFF_EVENT)) begin
                data_d = evt_vec;
            end else if (bus_addr_i == AW'(OFF_CUR)) begin
                data_d = DW'(cur_lvl);
            end else if (bus_addr_i == AW'(OFF_PREV)) begin
                data_d = DW'(prev_lvl);
            end else if (prio_hit) begin
                data_d = prio_rdata;
            end
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            RSP_IDLE:   bus_rdata_o = '0;
            RSP_ACCEPT: bus_rdata_o = data_q;
            RSP_REG:    bus_rdata_o = data_q;
            default:    bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/intc_accept_chk.sv
`timescale 1ns/1ps
module intc_accept_chk
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = NSRC_DEF,
    parameter int unsigned PW   = PW_DEF,
    parameter int unsigned AW   = AW_DEF,
    parameter int unsigned DW   = DW_DEF
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           re_i,
    input logic [AW-1:0]  addr_i,
    input logic [DW-1:0]  rdata_i,
    input logic           irq_i,
    input logic [PW-1:0]  cur_i,
    input logic [PW-1:0]  prev_i
);
    logic acc;
    assign acc = re_i && (addr_i == AW'(OFF_ACCEPT));

    p_vec_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && irq_i) |=> (rdata_i[VEC_SHIFT-1:0] == '0) &&
                           (rdata_i[DW-1:VEC_SHIFT] >= (DW-VEC_SHIFT)'(VEC_BASE)) &&
                           (rdata_i[DW-1:VEC_SHIFT] <  (DW-VEC_SHIFT)'(VEC_BASE + NSRC)));

    p_save_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && irq_i) |=> (prev_i == $past(cur_i)));

    p_raise_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && irq_i) |=> (cur_i > $past(cur_i)));

    p_empty_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && !irq_i) |=> ($stable(cur_i) && $stable(prev_i) && (rdata_i == '0)));

    p_prev_readonly_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc |=> $stable(prev_i));

    p_idle_rdata_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !re_i |=> (rdata_i == '0));
endmodule

bind intc_accept_top intc_accept_chk #(.NSRC(NSRC), .PW(PW), .AW(AW), .DW(DW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (bus_re_i),
    .addr_i  (bus_addr_i),
    .rdata_i (bus_rdata_o),
    .irq_i   (irq_o),
    .cur_i   (cur_lvl),
    .prev_i  (prev_lvl)
);

// File: tb/tb_intc_accept_top.sv
`timescale 1ns/1ps
module tb_intc_accept_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int mprio[N];
    int mcur, mprev, mevt;
    logic [31:0] mexp;

    always #10 clk = ~clk;

    intc_accept_top dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .bus_addr_i(addr),
        .bus_we_i(we), .bus_be_i(be), .bus_wdata_i(wdata), .bus_re_i(re),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    // Search from the top level downward; first index found at a level wins.
    function automatic int pick_src();
        for (int p = 15; p > mcur; p--) begin
            for (int i = 0; i < N; i++) begin
                if (req[i] && mprio[i] == p) return i;
            end
        end
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model, stepped every clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (mprio[i]) mprio[i] = 0;
            mcur = 0; mprev = 0; mevt = 0; mexp = '0;
        end else begin
            int w;
            logic [31:0] nx;
            w = pick_src();
            nx = '0;
            if (re) begin
                case (addr)
                    8'h18: begin
                        if (w >= 0) begin
                            nx = (w + 16) * 32;
                            mprev = mcur;
                            mcur = mprio[w];
                            mevt = nx;
                        end else begin
                            mevt = 0;
                        end
                    end
                    8'h20: nx = mevt;
                    8'h30: nx = mcur;
                    8'h34: nx = mprev;
                    8'h40, 8'h44: begin
                        int base;
                        base = (addr == 8'h44) ? 8 : 0;
                        for (int k = 0; k < 8; k++) nx = nx | (mprio[base+k] << (4*k));
                    end
                    default: nx = '0;
                endcase
            end else if (we) begin
                if (addr == 8'h30 && be[0]) mcur = wdata[3:0];
                if (addr == 8'h40 || addr == 8'h44) begin
                    int base;
                    base = (addr == 8'h44) ? 8 : 0;
                    for (int k = 0; k < 8; k++)
                        if (be[k/2]) mprio[base+k] = (wdata >> (4*k)) & 32'hF;
                end
            end
            mexp = nx;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk("R2 irq per cycle", {31'b0, irq}, {31'b0, pick_src() >= 0});
            chk("R10 rdata per cycle", rdata, mexp);
        end
    end

    task automatic op(input bit r, input bit w, input logic [7:0] a,
                      input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        re = r; we = w; addr = a; be = b; wdata = d;
        @(negedge clk);
        re = 0; we = 0; addr = '0; be = '0; wdata = '0;
        #3;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag, input logic [31:0] exp);
        op(1'b1, 1'b0, a, 4'h0, '0);
        chk(tag, rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
        op(1'b0, 1'b1, a, b, d);
    endtask

    task automatic set_req(input logic [N-1:0] v);
        @(negedge clk);
        req = v;
        #3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1: reset state
        chk("R1 rdata after reset", rdata, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd_chk(8'h30, "R1 current level", 32'h0);
        rd_chk(8'h34, "R1 saved level", 32'h0);
        rd_chk(8'h20, "R1 event", 32'h0);
        rd_chk(8'h44, "R1 priorities", 32'h0);

        // R9: priority 0 disables; R6 empty accept
        set_req('1);
        chk("R9 disabled sources no irq", {31'b0, irq}, 32'h0);
        rd_chk(8'h18, "R6 empty accept", 32'h0);
        set_req('0);

        // R9: programming and lanes
        wr(8'h40, 4'hF, 32'h9000_5000);
        wr(8'h44, 4'hF, 32'h0002_0090);
        rd_chk(8'h40, "R9 readback word0", 32'h9000_5000);
        rd_chk(8'h44, "R9 readback word1", 32'h0002_0090);
        wr(8'h40, 4'b0010, 32'hFFFF_FFFF);
        rd_chk(8'h40, "R9 lane enable", 32'h9000_FF00);
        wr(8'h40, 4'b0010, 32'h0000_5000);
        rd_chk(8'h40, "R9 lane restore", 32'h9000_5000);

        // R3/R5/R7: first acceptance
        set_req(16'h1008);
        chk("R2 irq with pending", {31'b0, irq}, 32'h1);
        rd_chk(8'h18, "R3 vector of source 3", 32'h260);
        rd_chk(8'h30, "R5 level raised", 32'h5);
        rd_chk(8'h34, "R5 level saved", 32'h0);
        rd_chk(8'h20, "R7 event holds vector", 32'h260);
        chk("R2 lower source masked", {31'b0, irq}, 32'h0);
        rd_chk(8'h18, "R6 nothing above level", 32'h0);
        rd_chk(8'h30, "R6 level kept", 32'h5);
        rd_chk(8'h34, "R6 saved kept", 32'h0);
        rd_chk(8'h20, "R7 event cleared", 32'h0);

        // R4: tie between sources 7 and 9
        wr(8'h30, 4'h1, 32'h0);
        set_req(16'h0288);
        rd_chk(8'h18, "R4 lower index wins tie", 32'h2E0);
        rd_chk(8'h18, "R4 equal priority masked", 32'h0);

        // Nested acceptance with non-zero saved level
        wr(8'h30, 4'h1, 32'h1);
        set_req(16'h1008);
        rd_chk(8'h18, "R3 accept over level 1", 32'h260);
        rd_chk(8'h34, "R5 saved level 1", 32'h1);
        set_req(16'h1088);
        rd_chk(8'h18, "R3 nested accept", 32'h2E0);
        rd_chk(8'h34, "R5 nested saved", 32'h5);
        rd_chk(8'h30, "R5 nested current", 32'h9);
        wr(8'h30, 4'h1, 32'h5);
        rd_chk(8'h30, "R8 restore write", 32'h5);
        chk("R2 irq after restore", {31'b0, irq}, 32'h1);

        // R8: ignored writes
        wr(8'h30, 4'b1110, 32'h0);
        rd_chk(8'h30, "R8 write without lane 0", 32'h5);
        wr(8'h34, 4'hF, 32'hF);
        rd_chk(8'h34, "R8 saved not writable", 32'h5);

        // R10: plain reads have no side effects
        rd_chk(8'h20, "R10 event read", 32'h2E0);
        rd_chk(8'h20, "R10 event read again", 32'h2E0);
        rd_chk(8'h30, "R10 level untouched", 32'h5);
        @(negedge clk); #3;
        chk("R10 idle rdata", rdata, 32'h0);

        // R2: strict comparison at the level boundary
        set_req(16'h1000);
        wr(8'h30, 4'h1, 32'h0);
        chk("R2 above level", {31'b0, irq}, 32'h1);
        wr(8'h30, 4'h1, 32'h2);
        chk("R2 equal level masked", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule